// File: doc/BRIEF.md
# External Clock Failure Supervisor

This block watches an external crystal clock from a reference clock domain and declares a failure when the watched clock stops producing edges. It holds the supervisor configuration: a sticky enable, a failure flag with an interrupt enable, and a sticky indicator that the safe internal source was forced. It also holds the oscillator enables, the internal-oscillator divider field and the clock-out selection. All of these are reached through a small register port.

A failure always switches the external oscillator off and raises the flag. What else happens depends on the current master clock, which the switch controller reports on `cur_master`.
- When the external source is the master, the block goes further. It forces a switch to the internal code E1h on the switch-controller interface, ahead of any software request in that cycle. It also turns the internal oscillator on, restores the divider to its reset value and sets the sticky auxiliary indicator.
- When the external source is not the master, the master clock is left alone.

In either case, a clock-out selection that points at the external source is moved to the internal divided source.

Register map (byte-wide, 3-bit address):
- 0 is control: bit0 enable (write 1 to set), bit1 interrupt enable, bit2 failure flag (write 0 clears), bit3 auxiliary indicator (read only).
- 1 is oscillators: bit0 internal enable, bit1 external enable, bit2 direct-clock mode (1 = direct external clock, 0 = crystal).
- 2 is the divider in bits 1:0.
- 3 is clock-out select in bits 1:0: 0 internal divided, 1 low-speed, 2 external, 3 master.
- 4 reads `cur_master`.

Top module: `clk_fail_sup`

## Requirements
- R1: After reset the enable, interrupt enable, failure flag, auxiliary indicator, external enable and direct-clock bits are 0. The internal enable is 1, the divider is 3, clock-out select is 0, and `irq` and `fail_pulse` are low.
- R2: The enable bit (control bit0) is set by writing 1 and cannot be cleared by any write.
- R3: Detection is armed only when enable=1, external enable=1 and direct-clock=0. Once armed with no watched-clock edge, `fail_pulse` rises exactly LIMIT-1 reference cycles after the arming write edge and lasts one cycle. A running watched clock never triggers it.
- R4: A failure sets the flag (control bit2) on the next edge; `irq` equals flag AND interrupt enable.
- R5: On a failure while `cur_master` equals EXT_CODE, the next cycle shows external enable 0, internal enable 1 and divider 3.
- R6: The auxiliary indicator (control bit3) sets on a failure while the external source is master, and no write clears it.
- R7: Writing 0 to control bit2 clears the flag; writing 1 leaves it unchanged.
- R8: On a failure while the external source is not master, only the external enable clears; the internal enable, divider and auxiliary indicator keep their values and `sw_code` passes `sw_tgt`.
- R9: On any failure a clock-out select of 2 becomes 0; values 0, 1 and 3 are kept.
- R10: Divider writes are ignored while the failure flag is 1.
- R11: In a master-failure cycle `sw_go`=1, `sw_forced`=1 and `sw_code`=E1h whatever `sw_req`/`sw_tgt` are. In every other cycle `sw_go`=`sw_req`, `sw_code`=`sw_tgt` and `sw_forced`=0.
- R12: A read of address 4 returns `cur_master`; unmapped addresses and cycles that are not reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Watched external clock |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cur_master | input | 8 | Current master clock code |
| sw_req | input | 1 | Software switch request |
| sw_tgt | input | 8 | Software switch target code |
| sw_go | output | 1 | Switch request to switch controller |
| sw_code | output | 8 | Switch target to switch controller |
| sw_forced | output | 1 | Request is a failure override |
| fail_pulse | output | 1 | One-cycle failure event |
| irq | output | 1 | Failure interrupt |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| hsi_div | output | 2 | Internal oscillator divider |
| ckout_sel | output | 2 | Clock-out source select |
| aux_forced | output | 1 | Auxiliary source forced (sticky) |

## Verification
Each failure pulse is counted to the cycle: the bench stops the watched clock and arms the detector with a single register write. It then counts falling reference edges until `fail_pulse` appears and expects exactly LIMIT-1 of them. The switch outputs are checked in that same pulse cycle, since they are combinational. The register effects and `irq` are checked one cycle later, because they are registered. Bus reads and the outputs are sampled at the falling edge after the write edge, so every register effect has settled. Checks that no failure is raised watch for at least three detection windows.

// File: rtl/clk_sup_pkg.sv
package clk_sup_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADR_OSC  = 3'd1;
  localparam logic [AW-1:0] ADR_DIV  = 3'd2;
  localparam logic [AW-1:0] ADR_CKO  = 3'd3;
  localparam logic [AW-1:0] ADR_MST  = 3'd4;

  localparam logic [1:0] DIV_RESET = 2'b11;

  typedef enum logic [1:0] {
    CKO_INT_DIV = 2'd0,
    CKO_LOW     = 2'd1,
    CKO_EXT     = 2'd2,
    CKO_MASTER  = 2'd3
  } cko_sel_e;
endpackage

// File: rtl/clk_sup_rst_sync.sv
module clk_sup_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/clk_sup_edge_mon.sv
module clk_sup_edge_mon #(
  parameter int LIMIT = 64
) (
  input  logic mon_clk,
  input  logic mon_rst_n,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic armed,
  output logic fail_pulse
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          tog_q;
  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_seen;
  logic          hit;

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) tog_q <= 1'b0;
    else            tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tog_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_seen = s2_q ^ s3_q;
  assign hit       = armed && !edge_seen && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!armed || edge_seen || hit) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fail_pulse = hit;

  AST_PULSE_NEEDS_ARM: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_pulse |-> armed) else $error("pulse while disarmed"); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_pulse |=> !fail_pulse) else $error("pulse too long"); // R3
  AST_EDGE_BLOCKS_PULSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    edge_seen |-> !fail_pulse) else $error("pulse with edge"); // R3
endmodule

// File: rtl/clk_sup_regs.sv
module clk_sup_regs
  import clk_sup_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] cur_master,
  input  logic          fail_pulse,
  input  logic          master_ext,
  output logic          sup_en,
  output logic          fail_det,
  output logic          irq,
  output logic          aux_forced,
  output logic          int_osc_en,
  output logic          ext_osc_en,
  output logic          ext_direct,
  output logic [1:0]    hsi_div,
  output logic [1:0]    ckout_sel
);
  logic sup_q, sup_d, irqen_q, irqen_d, fail_q, fail_d, aux_q, aux_d;
  logic int_q, int_d, ext_q, ext_d, byp_q, byp_d;
  logic [1:0] div_q, div_d, cko_q, cko_d;
  logic wr_ctrl, wr_osc, wr_div, wr_cko, master_fail;
  logic [DW-1:0] rd_mux;

  assign wr_ctrl     = bus_sel && bus_we && (bus_addr == ADR_CTRL);
  assign wr_osc      = bus_sel && bus_we && (bus_addr == ADR_OSC);
  assign wr_div      = bus_sel && bus_we && (bus_addr == ADR_DIV);
  assign wr_cko      = bus_sel && bus_we && (bus_addr == ADR_CKO);
  assign master_fail = fail_pulse && master_ext;

  always_comb begin
    sup_d   = sup_q | (wr_ctrl & bus_wdata[0]);
    irqen_d = wr_ctrl ? bus_wdata[1] : irqen_q;
    fail_d  = fail_q;
    if (wr_ctrl && !bus_wdata[2]) fail_d = 1'b0;
    if (fail_pulse)               fail_d = 1'b1;
    aux_d   = aux_q | master_fail;

    int_d = wr_osc ? bus_wdata[0] : int_q;
    ext_d = wr_osc ? bus_wdata[1] : ext_q;
    byp_d = wr_osc ? bus_wdata[2] : byp_q;
    if (fail_pulse)  ext_d = 1'b0;
    if (master_fail) int_d = 1'b1;

    div_d = div_q;
    if (wr_div && !fail_q) div_d = bus_wdata[1:0];
    if (master_fail)       div_d = DIV_RESET;

    cko_d = wr_cko ? bus_wdata[1:0] : cko_q;
    if (fail_pulse && (cko_d == CKO_EXT)) cko_d = CKO_INT_DIV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q   <= 1'b0;
      irqen_q <= 1'b0;
      fail_q  <= 1'b0;
      aux_q   <= 1'b0;
      int_q   <= 1'b1;
      ext_q   <= 1'b0;
      byp_q   <= 1'b0;
      div_q   <= DIV_RESET;
      cko_q   <= CKO_INT_DIV;
    end else begin
      sup_q   <= sup_d;
      irqen_q <= irqen_d;
      fail_q  <= fail_d;
      aux_q   <= aux_d;
      int_q   <= int_d;
      ext_q   <= ext_d;
      byp_q   <= byp_d;
      div_q   <= div_d;
      cko_q   <= cko_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADR_CTRL: rd_mux = {4'b0, aux_q, fail_q, irqen_q, sup_q};
      ADR_OSC:  rd_mux = {5'b0, byp_q, ext_q, int_q};
      ADR_DIV:  rd_mux = {6'b0, div_q};
      ADR_CKO:  rd_mux = {6'b0, cko_q};
      ADR_MST:  rd_mux = cur_master;
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata  = (bus_sel && !bus_we) ? rd_mux : '0;
  assign sup_en     = sup_q;
  assign fail_det   = fail_q;
  assign irq        = fail_q & irqen_q;
  assign aux_forced = aux_q;
  assign int_osc_en = int_q;
  assign ext_osc_en = ext_q;
  assign ext_direct = byp_q;
  assign hsi_div    = div_q;
  assign ckout_sel  = cko_q;

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sup_q |=> sup_q) else $error("enable dropped"); // R2
  AST_FLAG_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> fail_q) else $error("flag not set"); // R4
  AST_MASTER_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    master_fail |=> (aux_q && int_q && !ext_q && div_q == DIV_RESET))
    else $error("master recovery incomplete"); // R5
  AST_AUX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    aux_q |=> aux_q) else $error("aux dropped"); // R6
  AST_SLAVE_FAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse && !master_ext && !wr_osc && !wr_div) |=>
      (!ext_q && int_q == $past(int_q) && div_q == $past(div_q) && aux_q == $past(aux_q)))
    else $error("non-master failure touched master state"); // R8
  AST_CKO_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse && cko_q == CKO_EXT && !wr_cko) |=> cko_q == CKO_INT_DIV)
    else $error("clock-out not moved"); // R9
  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !fail_pulse) |=> div_q == $past(div_q)) else $error("divider changed"); // R10
endmodule

// File: rtl/clk_fail_sup.sv
module clk_fail_sup #(
  parameter int          LIMIT    = 64,
  parameter logic [7:0]  EXT_CODE = 8'hB4,
  parameter logic [7:0]  INT_CODE = 8'hE1
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       mon_clk,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] cur_master,
  input  logic       sw_req,
  input  logic [7:0] sw_tgt,
  output logic       sw_go,
  output logic [7:0] sw_code,
  output logic       sw_forced,
  output logic       fail_pulse,
  output logic       irq,
  output logic       int_osc_en,
  output logic       ext_osc_en,
  output logic [1:0] hsi_div,
  output logic [1:0] ckout_sel,
  output logic       aux_forced
);
  logic srst_n, sup_en, fail_det, ext_direct, armed, master_ext, pulse;

  clk_sup_rst_sync u_rst (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign armed      = sup_en && ext_osc_en && !ext_direct;
  assign master_ext = (cur_master == EXT_CODE);

  clk_sup_edge_mon #(.LIMIT(LIMIT)) u_mon (
    .mon_clk    (mon_clk),
    .mon_rst_n  (rst_n),
    .ref_clk    (ref_clk),
    .rst_n      (srst_n),
    .armed      (armed),
    .fail_pulse (pulse)
  );

  clk_sup_regs u_regs (
    .clk        (ref_clk),
    .rst_n      (srst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cur_master (cur_master),
    .fail_pulse (pulse),
    .master_ext (master_ext),
    .sup_en     (sup_en),
    .fail_det   (fail_det),
    .irq        (irq),
    .aux_forced (aux_forced),
    .int_osc_en (int_osc_en),
    .ext_osc_en (ext_osc_en),
    .ext_direct (ext_direct),
    .hsi_div    (hsi_div),
    .ckout_sel  (ckout_sel)
  );

  always_comb begin
    sw_forced = pulse && master_ext;
    sw_go     = sw_forced ? 1'b1 : sw_req;
    sw_code   = sw_forced ? INT_CODE : sw_tgt;
  end

  assign fail_pulse = pulse;

  AST_OVERRIDE_WINS: assert property (@(posedge ref_clk) disable iff (!srst_n)
    (pulse && master_ext) |-> (sw_go && sw_forced && sw_code == INT_CODE))
    else $error("override lost"); // R11
  AST_PASS_THROUGH: assert property (@(posedge ref_clk) disable iff (!srst_n)
    !(pulse && master_ext) |-> (sw_go == sw_req && sw_code == sw_tgt && !sw_forced))
    else $error("pass-through broken"); // R11
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge ref_clk) disable iff (!srst_n)
    irq |-> fail_det) else $error("irq without flag"); // R4
endmodule

// File: tb/tb_clk_fail_sup.sv
`timescale 1ns/1ps
module tb_clk_fail_sup;
  localparam int LIMIT = 64;
  localparam logic [7:0] EXT = 8'hB4;
  localparam logic [7:0] INTC = 8'hE1;

  logic ref_clk = 1'b0, mon_clk = 1'b0, mon_run = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, sw_req = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, cur_master = 8'hE1, sw_tgt = '0;
  logic [7:0] bus_rdata, sw_code;
  logic sw_go, sw_forced, fail_pulse, irq, int_osc_en, ext_osc_en, aux_forced;
  logic [1:0] hsi_div, ckout_sel;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  clk_fail_sup #(.LIMIT(LIMIT), .EXT_CODE(EXT), .INT_CODE(INTC)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_master(cur_master),
    .sw_req(sw_req), .sw_tgt(sw_tgt), .sw_go(sw_go), .sw_code(sw_code),
    .sw_forced(sw_forced), .fail_pulse(fail_pulse), .irq(irq),
    .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en), .hsi_div(hsi_div),
    .ckout_sel(ckout_sel), .aux_forced(aux_forced)
  );

  always #5 ref_clk = ~ref_clk;
  always begin
    #13;
    if (mon_run) mon_clk = ~mon_clk;
  end
  always @(negedge ref_clk) if (fail_pulse) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge ref_clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge ref_clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge ref_clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic quiet(input string req, input int cycles);
    int p0;
    logic [7:0] r;
    p0 = pulses;
    repeat (cycles) @(negedge ref_clk);
    rd(3'd0, r);
    chk(pulses == p0 && r[2] == 1'b0, req, pulses - p0, 0);
  endtask

  task automatic fail_case(input bit master, input logic [1:0] cko);
    int n;
    logic aux0;
    logic [7:0] r;
    logic [1:0] cko_exp;
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h01);
    wr(3'd3, {6'b0, cko});
    @(negedge ref_clk);
    cur_master = master ? EXT : 8'hD2;
    sw_req = 1'b1; sw_tgt = 8'h5A;
    aux0 = aux_forced;
    wr(3'd1, 8'h02);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
    end while (!fail_pulse && n < 200);
    chk(n == LIMIT - 1, "R3 pulse timing", n, LIMIT - 1);
    chk(sw_go == 1'b1 && sw_forced == master, "R11 forced flag", sw_forced, master);
    chk(sw_code == (master ? INTC : 8'h5A), master ? "R11 override code" : "R8 passthrough code",
        sw_code, master ? INTC : 8'h5A);
    @(negedge ref_clk);
    chk(ext_osc_en == 1'b0, master ? "R5 ext off" : "R8 ext off", ext_osc_en, 0);
    chk(int_osc_en == master, master ? "R5 int on" : "R8 int kept", int_osc_en, master);
    chk(hsi_div == (master ? 2'd3 : 2'd1), master ? "R5 div reset" : "R8 div kept",
        hsi_div, master ? 3 : 1);
    chk(aux_forced == (master ? 1'b1 : aux0), master ? "R6 aux set" : "R8 aux kept",
        aux_forced, master ? 1 : aux0);
    cko_exp = (cko == 2'd2) ? 2'd0 : cko;
    chk(ckout_sel == cko_exp, "R9 clock-out", ckout_sel, cko_exp);
    chk(irq == 1'b1, "R4 irq", irq, 1);
    chk(fail_pulse == 1'b0 && sw_forced == 1'b0 && sw_code == 8'h5A, "R11 after pulse", sw_code, 8'h5A);
    rd(3'd0, r);
    chk(r[2] == 1'b1, "R4 flag set", r[2], 1);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    // R1 reset state
    rd(3'd0, r); chk(r == 8'h00, "R1 control", r, 0);
    rd(3'd1, r); chk(r == 8'h01, "R1 oscillators", r, 1);
    rd(3'd2, r); chk(r == 8'h03, "R1 divider", r, 3);
    rd(3'd3, r); chk(r == 8'h00, "R1 clock-out", r, 0);
    chk(irq == 0 && fail_pulse == 0 && aux_forced == 0 && int_osc_en == 1 && ext_osc_en == 0,
        "R1 outputs", {irq, fail_pulse, aux_forced, int_osc_en, ext_osc_en}, 5'b00010);

    // R12 read path
    cur_master = 8'h3C;
    rd(3'd4, r); chk(r == 8'h3C, "R12 master read", r, 8'h3C);
    rd(3'd7, r); chk(r == 8'h00, "R12 unmapped", r, 0);
    @(negedge ref_clk); chk(bus_rdata == 8'h00, "R12 idle read", bus_rdata, 0);

    // R11 pass-through without failure
    sw_req = 1'b1; sw_tgt = 8'hC3; #1;
    chk(sw_go == 1 && sw_code == 8'hC3 && sw_forced == 0, "R11 pass", sw_code, 8'hC3);
    sw_req = 1'b0; #1;
    chk(sw_go == 0, "R11 idle", sw_go, 0);

    // R3 arming sweep
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 2; b++) begin
        wr(3'd1, {5'b0, b[0], e[0], 1'b1});
        quiet("R3 disabled", 3 * LIMIT);
      end
    end
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h07); quiet("R3 direct-clock mode", 3 * LIMIT);
    wr(3'd1, 8'h01); quiet("R3 external off", 3 * LIMIT);
    mon_run = 1'b1;
    repeat (10) @(negedge ref_clk);
    wr(3'd1, 8'h03); quiet("R3 running clock", 5 * LIMIT);
    wr(3'd1, 8'h01);
    mon_run = 1'b0;
    repeat (10) @(negedge ref_clk);

    // failure sweep: non-master first, then master
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        fail_case(m[0], c[1:0]);

    // R10, R7, R2, R6 after a failure
    wr(3'd2, 8'h00);
    chk(hsi_div == 2'd3, "R10 divider locked", hsi_div, 3);
    wr(3'd0, 8'h07);
    rd(3'd0, r); chk(r[2] == 1'b1, "R7 write one keeps flag", r[2], 1);
    wr(3'd0, 8'h02);
    rd(3'd0, r);
    chk(r[2] == 1'b0, "R7 flag cleared", r[2], 0);
    chk(r[0] == 1'b1, "R2 enable sticky", r[0], 1);
    chk(r[3] == 1'b1 && aux_forced == 1'b1, "R6 aux sticky", r[3], 1);
    chk(irq == 1'b0, "R4 irq cleared", irq, 0);
    wr(3'd2, 8'h02);
    chk(hsi_div == 2'd2, "R10 divider writable", hsi_div, 2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule